// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the running IEEE 1588 time for an Ethernet MAC's timestamp unit. The time is a 30-bit nanoseconds field and a 48-bit seconds count. On every cycle where the timer enable `tick` is high, the nanoseconds advance by a programmed step. The step is a whole number of nanoseconds plus a 16-bit binary fraction. The fraction builds up in an accumulator, and each carry out of that accumulator adds one more nanosecond. The current seconds and nanoseconds are exported all the time, so capture logic elsewhere can sample them.

Software controls the counter through a simple write port and a combinational read port. It can load the nanoseconds, load the seconds, change the step and apply a one-shot signed nanosecond offset. Two small state machines order the multi-word writes. The seconds staging machine has two states. ST_SEC_SYNC goes to ST_SEC_HI_HELD on a high-seconds write, and a low-seconds write returns it to ST_SEC_SYNC. The increment staging machine also has two states. ST_INC_LIVE goes to ST_INC_SUB_HELD on a fraction write, and a whole-nanosecond increment write returns it to ST_INC_LIVE. Reaching the commit write while a staged value is held is what makes that staged value take effect.

Top module: `ptp_tod_counter`

## Requirements
- R1: In a cycle where `tick` is high, the nanoseconds grow by the active whole-nanosecond increment plus the fraction carry. In a cycle with `tick` low and no write, the time does not change.
- R2: The fraction accumulator is 16 bits wide. On each tick it adds the active fraction, and a carry out of bit 15 adds one extra nanosecond on that tick.
- R3: A write to address 4 (fraction, data bits 15:0) is held pending, and the active fraction and read-back stay unchanged. A write to address 3 (whole ns, data bits 7:0) installs the new whole value and, if a fraction is pending, also installs that fraction.
- R4: The nanoseconds stay below 1,000,000,000. Reaching that value subtracts it from the nanoseconds and adds one to the seconds, and the carry ripples across all 48 seconds bits.
- R5: A write to address 2 (data bits 15:0) only stages the high seconds. A write to address 1 loads seconds = {staged high, data} when a high value is staged, and {current high, data} when none is. In that cycle the tick still advances the nanoseconds, but any carry into seconds is dropped.
- R6: A write to address 0 loads data bits 29:0 into the nanoseconds directly. Any tick in that cycle does not move the nanoseconds, though the fraction accumulator still advances. The seconds are unchanged.
- R7: A write to address 5 applies its offset once. Bit 31 is the sign, with 0 meaning add and 1 meaning subtract. Bits 29:0 hold a magnitude below one second. If a subtraction goes below zero, the block borrows one second and adds 1,000,000,000.
- R8: An offset write in a tick cycle is combined with that tick's step in a single update, so no step is lost.
- R9: When both the whole and the fraction increments are zero, the time stays still even while `tick` is high.
- R10: `rd_data` returns live values for the address on `rd_addr`: 0 is nanoseconds, 1 is seconds bits 31:0, 2 is seconds bits 47:32, 3 is the active whole increment and 4 is the active fraction. Address 5 and unused addresses read zero.
- R11: After reset, the time, the increments, the accumulator and both staging machines are all zero or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer enable; one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Live read data |
| tod_ns | output | 30 | Current nanoseconds |
| tod_sec | output | 48 | Current seconds |

## Verification
Two functions can fall in the same cycle: the tick step, and an offset or time-load write. The bench provokes this by issuing adjust writes, nanoseconds loads and low-seconds loads with `tick` high. It places them right at the nanoseconds wrap and right below zero, where a carry or borrow decides the result. Each cycle's time and read-back are compared with a behavioural model that combines step and offset arithmetically. A lost step, a double carry or a stray borrow therefore appears as a mismatch in that very cycle.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_NS     = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEC_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEC_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_INC_NS = 3'd3;
    localparam logic [ADDR_W-1:0] A_INC_FR = 3'd4;
    localparam logic [ADDR_W-1:0] A_ADJ    = 3'd5;

    localparam longint NS_PER_SEC = 64'd1000000000;

    typedef enum logic {ST_SEC_SYNC, ST_SEC_HI_HELD} sec_st_t;
    typedef enum logic {ST_INC_LIVE, ST_INC_SUB_HELD} inc_st_t;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
    import ptp_tod_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NS_W     = 30,
    parameter int SECL_W   = 32,
    parameter int SECH_W   = 16,
    parameter int INC_NS_W = 8,
    parameter int FRAC_W   = 16,
    parameter int SIGN_BIT = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [SECH_W-1:0]        live_sec_hi,
    output logic [INC_NS_W-1:0]      inc_ns,
    output logic [FRAC_W-1:0]        inc_frac,
    output logic                     ns_load,
    output logic [NS_W-1:0]          ns_val,
    output logic                     sec_load,
    output logic [SECL_W+SECH_W-1:0] sec_val,
    output logic                     adj_go,
    output logic                     adj_neg,
    output logic [NS_W-1:0]          adj_mag
);
    sec_st_t sec_st, sec_st_n;
    inc_st_t inc_st, inc_st_n;
    logic [SECH_W-1:0] hi_stage;
    logic [FRAC_W-1:0] frac_stage;

    logic w_ns, w_lo, w_hi, w_incns, w_frac, w_adj;
    assign w_ns    = wr_en && (wr_addr == A_NS);
    assign w_lo    = wr_en && (wr_addr == A_SEC_LO);
    assign w_hi    = wr_en && (wr_addr == A_SEC_HI);
    assign w_incns = wr_en && (wr_addr == A_INC_NS);
    assign w_frac  = wr_en && (wr_addr == A_INC_FR);
    assign w_adj   = wr_en && (wr_addr == A_ADJ);

    always_comb begin
        sec_st_n = sec_st;
        unique case (sec_st)
            ST_SEC_SYNC:    if (w_hi) sec_st_n = ST_SEC_HI_HELD;
            ST_SEC_HI_HELD: if (w_lo) sec_st_n = ST_SEC_SYNC;
            default:        sec_st_n = ST_SEC_SYNC;
        endcase
        inc_st_n = inc_st;
        unique case (inc_st)
            ST_INC_LIVE:     if (w_frac)  inc_st_n = ST_INC_SUB_HELD;
            ST_INC_SUB_HELD: if (w_incns) inc_st_n = ST_INC_LIVE;
            default:         inc_st_n = ST_INC_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_st     <= ST_SEC_SYNC;
            inc_st     <= ST_INC_LIVE;
            hi_stage   <= '0;
            frac_stage <= '0;
            inc_ns     <= '0;
            inc_frac   <= '0;
        end else begin
            sec_st <= sec_st_n;
            inc_st <= inc_st_n;
            if (w_hi)   hi_stage   <= wr_data[SECH_W-1:0];
            if (w_frac) frac_stage <= wr_data[FRAC_W-1:0];
            if (w_incns) begin
                inc_ns <= wr_data[INC_NS_W-1:0];
                if (inc_st == ST_INC_SUB_HELD) inc_frac <= frac_stage;
            end
        end
    end

    always_comb begin
        ns_load  = w_ns;
        ns_val   = wr_data[NS_W-1:0];
        sec_load = w_lo;
        sec_val  = (sec_st == ST_SEC_HI_HELD) ? {hi_stage, wr_data[SECL_W-1:0]}
                                              : {live_sec_hi, wr_data[SECL_W-1:0]};
        adj_go   = w_adj;
        adj_neg  = wr_data[SIGN_BIT];
        adj_mag  = wr_data[NS_W-1:0];
    end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
    import ptp_tod_pkg::*;
#(
    parameter int NS_W     = 30,
    parameter int SEC_W    = 48,
    parameter int INC_NS_W = 8,
    parameter int FRAC_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [INC_NS_W-1:0] inc_ns,
    input  logic [FRAC_W-1:0]   inc_frac,
    input  logic                ns_load,
    input  logic [NS_W-1:0]     ns_val,
    input  logic                sec_load,
    input  logic [SEC_W-1:0]    sec_val,
    input  logic                adj_go,
    input  logic                adj_neg,
    input  logic [NS_W-1:0]     adj_mag,
    output logic [NS_W-1:0]     tod_ns,
    output logic [SEC_W-1:0]    tod_sec
);
    localparam int TW = NS_W + 3;
    localparam logic [TW-1:0] BILLION = TW'(NS_PER_SEC);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic [INC_NS_W:0] step;
    logic [TW-1:0]     total;
    logic [NS_W-1:0]   ns_n;
    logic [SEC_W-1:0]  sec_n;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, inc_frac};
        step    = tick ? ({1'b0, inc_ns} + {{INC_NS_W{1'b0}}, acc_sum[FRAC_W]}) : '0;
        total   = TW'(tod_ns) + TW'(step);
        if (adj_go) total = adj_neg ? (total - TW'(adj_mag)) : (total + TW'(adj_mag));
        sec_n = tod_sec;
        ns_n  = total[NS_W-1:0];
        if (total[TW-1]) begin
            ns_n  = NS_W'(total + BILLION);
            sec_n = tod_sec - 1'b1;
        end else if (total >= BILLION) begin
            ns_n  = NS_W'(total - BILLION);
            sec_n = tod_sec + 1'b1;
        end
        if (ns_load) begin
            ns_n  = ns_val;
            sec_n = tod_sec;
        end
        if (sec_load) sec_n = sec_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            tod_ns  <= '0;
            tod_sec <= '0;
        end else begin
            if (tick) acc_q <= acc_sum[FRAC_W-1:0];
            tod_ns  <= ns_n;
            tod_sec <= sec_n;
        end
    end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NS_W     = 30,
    parameter int SECL_W   = 32,
    parameter int SECH_W   = 16,
    parameter int INC_NS_W = 8,
    parameter int FRAC_W   = 16,
    parameter int SIGN_BIT = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [2:0]               rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NS_W-1:0]          tod_ns,
    output logic [SECL_W+SECH_W-1:0] tod_sec
);
    localparam int SEC_W = SECL_W + SECH_W;

    logic [INC_NS_W-1:0] inc_ns;
    logic [FRAC_W-1:0]   inc_frac;
    logic                ns_load, sec_load, adj_go, adj_neg;
    logic [NS_W-1:0]     ns_val, adj_mag;
    logic [SEC_W-1:0]    sec_val;

    ptp_tod_regs #(
        .DATA_W(DATA_W), .NS_W(NS_W), .SECL_W(SECL_W), .SECH_W(SECH_W),
        .INC_NS_W(INC_NS_W), .FRAC_W(FRAC_W), .SIGN_BIT(SIGN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .live_sec_hi(tod_sec[SEC_W-1:SECL_W]),
        .inc_ns(inc_ns), .inc_frac(inc_frac),
        .ns_load(ns_load), .ns_val(ns_val),
        .sec_load(sec_load), .sec_val(sec_val),
        .adj_go(adj_go), .adj_neg(adj_neg), .adj_mag(adj_mag)
    );

    ptp_tod_core #(
        .NS_W(NS_W), .SEC_W(SEC_W), .INC_NS_W(INC_NS_W), .FRAC_W(FRAC_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .inc_ns(inc_ns), .inc_frac(inc_frac),
        .ns_load(ns_load), .ns_val(ns_val),
        .sec_load(sec_load), .sec_val(sec_val),
        .adj_go(adj_go), .adj_neg(adj_neg), .adj_mag(adj_mag),
        .tod_ns(tod_ns), .tod_sec(tod_sec)
    );

    always_comb begin
        unique case (rd_addr)
            A_NS:     rd_data = DATA_W'(tod_ns);
            A_SEC_LO: rd_data = DATA_W'(tod_sec[SECL_W-1:0]);
            A_SEC_HI: rd_data = DATA_W'(tod_sec[SEC_W-1:SECL_W]);
            A_INC_NS: rd_data = DATA_W'(inc_ns);
            A_INC_FR: rd_data = DATA_W'(inc_frac);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [29:0] tod_ns,
    input logic [47:0] tod_sec,
    input logic [7:0]  inc_ns,
    input logic [15:0] inc_frac
);
    AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tod_ns < 30'd1000000000); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(tod_ns) && $stable(tod_sec))); // R1

    AST_ZERO_STEP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && inc_ns == 8'd0 && inc_frac == 16'd0)
        |=> ($stable(tod_ns) && $stable(tod_sec))); // R9

    AST_FRAC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4) |=> $stable(inc_frac)); // R3

    AST_NS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (tod_ns == $past(wr_data[29:0]))); // R6

    AST_HI_NOT_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd2)
        |=> (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 48'd1)); // R5
endmodule

bind ptp_tod_counter ptp_tod_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tod_ns(tod_ns), .tod_sec(tod_sec),
    .inc_ns(inc_ns), .inc_frac(inc_frac)
);

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam longint BIL = 64'd1000000000;
    localparam longint M48 = (64'd1 << 48) - 1;

    logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic [29:0] tod_ns;
    logic [47:0] tod_sec;

    int total = 0, bad = 0;
    bit finished = 0;

    longint m_ns = 0, m_sec = 0, m_frac = 0, m_ins = 0, m_isub = 0;
    longint m_fstage = 0, m_hstage = 0;
    bit m_fheld = 0, m_hheld = 0;
    int rd_rot = 0;

    ptp_tod_counter u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tod_ns(tod_ns), .tod_sec(tod_sec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint model_read(int a);
        case (a)
            0: return m_ns;
            1: return m_sec & 64'hFFFF_FFFF;
            2: return (m_sec >> 32) & 64'hFFFF;
            3: return m_ins;
            4: return m_isub;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(bit tk, bit we, int a, logic [31:0] d, string tag);
        longint step, t, sd, nns, nsec, fs;
        tick = tk; wr_en = we; wr_addr = 3'(a); wr_data = d;
        rd_addr = 3'(rd_rot % 6); rd_rot++;
        step = 0;
        if (tk) begin
            fs = m_frac + m_isub;
            step = m_ins + (fs >> 16);
        end
        t = m_ns + step;
        if (we && a == 5) t = d[31] ? t - longint'(d[29:0]) : t + longint'(d[29:0]);
        sd = 0;
        if (t >= BIL) begin t -= BIL; sd = 1; end
        else if (t < 0) begin t += BIL; sd = -1; end
        nns = t; nsec = (m_sec + sd) & M48;
        if (we && a == 0) begin nns = longint'(d[29:0]); nsec = m_sec; end
        if (we && a == 1) begin
            nsec = ((m_hheld ? m_hstage : (m_sec >> 32)) << 32) | longint'(d);
            m_hheld = 0;
        end
        if (we && a == 2) begin m_hstage = longint'(d[15:0]); m_hheld = 1; end
        if (we && a == 4) begin m_fstage = longint'(d[15:0]); m_fheld = 1; end
        if (we && a == 3) begin
            m_ins = longint'(d[7:0]);
            if (m_fheld) m_isub = m_fstage;
            m_fheld = 0;
        end
        if (tk) m_frac = (m_frac + (tk ? 0 : 0) + 0) ; // placeholder-free: updated below
        if (tk) m_frac = fs & 64'hFFFF;
        m_ns = nns; m_sec = nsec;
        @(posedge clk); #1;
        check(tag, "ns", longint'(tod_ns), m_ns);
        check(tag, "sec", longint'(tod_sec), m_sec);
        check(tag, "rd", longint'(rd_data), model_read(int'(rd_addr)));
    endtask

    task automatic rd_chk(int a, longint exp, string tag);
        rd_addr = 3'(a); wr_en = 0; tick = 0;
        #1;
        check(tag, "read", longint'(rd_data), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        for (int a = 0; a < 6; a++) rd_chk(a, 0, "R11");
        rst_n = 1;
        @(posedge clk); #1;
        // R9: zero increments, ticks do nothing
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R9");
        // R3: fraction held pending
        cyc(0, 1, 4, 32'h0000_4000, "R3");
        rd_chk(4, 0, "R3");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R3");
        cyc(1, 1, 3, 32'd8, "R3");
        rd_chk(4, 32'h4000, "R3");
        rd_chk(3, 8, "R3");
        // R1/R2: steady stepping with gaps
        for (int i = 0; i < 40; i++) cyc((i % 3) != 0, 0, 0, 0, "R2");
        cyc(1, 1, 4, 32'h0000_FFFF, "R2");
        cyc(1, 1, 3, 32'd255, "R2");
        for (int i = 0; i < 60; i++) cyc(1, 0, 0, 0, "R2");
        // R6: ns load during tick
        cyc(1, 1, 0, 32'd999_999_000, "R6");
        // R4: wrap
        for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, "R4");
        // R5: 48-bit seconds, staged high
        cyc(1, 1, 2, 32'h0000_0001, "R5");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R5");
        cyc(0, 1, 0, 32'd999_999_900, "R6");
        cyc(0, 1, 1, 32'hFFFF_FFFF, "R5");
        rd_chk(2, 1, "R5");
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R4");
        rd_chk(2, 2, "R4");
        // R5: low write without staged high keeps live high; carry dropped
        cyc(0, 1, 0, 32'd999_999_990, "R5");
        cyc(1, 1, 1, 32'd7, "R5");
        // R7: add and subtract with borrow
        cyc(0, 1, 5, 32'd500, "R7");
        cyc(0, 1, 0, 32'd100, "R7");
        cyc(0, 1, 5, 32'h8000_0000 | 32'd300, "R7");
        cyc(0, 1, 5, 32'h8000_0000 | 32'd999_000_000, "R7");
        // R8: offset with tick at the edges
        cyc(0, 1, 0, 32'd10, "R8");
        cyc(1, 1, 5, 32'h8000_0000 | 32'd200, "R8");
        cyc(0, 1, 0, 32'd999_999_700, "R8");
        cyc(1, 1, 5, 32'd100, "R8");
        for (int i = 0; i < 20; i++) cyc(1, (i % 4) == 0, 5, (i % 8 == 0) ? 32'h8000_0000 | 32'd777 : 32'd12345, "R8");
        // R10: reads of address 5 and unused addresses
        rd_chk(5, 0, "R10");
        rd_chk(6, 0, "R10");
        rd_chk(7, 0, "R10");
        // R9: back to zero increments
        cyc(1, 1, 4, 32'd0, "R9");
        cyc(1, 1, 3, 32'd0, "R9");
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, "R9");
        // R1: long mixed run
        cyc(0, 1, 4, 32'h0000_3333, "R1");
        cyc(0, 1, 3, 32'd40, "R1");
        for (int i = 0; i < 3000; i++) cyc((i % 5) != 2, 0, 0, 0, "R1");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule